// File: doc/BRIEF.md
# Display Controller Register File

This block is the memory-mapped configuration and status front end of a raster display controller. It sits on a simple 32-bit peripheral bus. It holds four timing words, two frame base addresses, a control word, a four-bit interrupt mask and the raw event status. It also holds a word-indexed colour palette window and a word-indexed cursor image window. From the first two timing words it derives the active picture width and height. It hands the fetch engine a start request and a watermark choice, and it drives one level-sensitive interrupt line.

The fetch engine reports three kinds of event with single-cycle pulses: buffer underflow, a new frame base being taken up, and a bus-master error. Each pulse sets a sticky raw status bit. Software masks these bits and clears them through a write-only clear register. The fetch engine also supplies its current fetch address, and software can read it back. Each bus access lasts one cycle. Read data and the error flag come back on the following cycle.

Top module: `dctl_regfile`

Register offsets: 0x000 timing 0, 0x004 timing 1, 0x008 timing 2, 0x00C timing 3, 0x010 upper base, 0x014 lower base, 0x018 control, 0x01C mask, 0x020 raw status (read-only), 0x024 masked status (read-only), 0x028 clear (write-only), 0x02C and 0x030 current address (read-only). Status bit positions: bit 0 underflow, bit 1 base update, bit 2 vertical compare, bit 3 master error. Control bit positions: bit 0 enable, bit 11 power, bit 16 watermark. Access size codes: 0 byte, 1 halfword, 2 word, 3 illegal.

## Requirements
- R1: The active width equals 16 × (bits [7:2] of timing 0 + 1). It follows the value of timing 0 as soon as that register is written.
- R2: The active height equals bits [9:0] of timing 1 plus one.
- R3: Masked status always equals mask AND raw status. The interrupt line is high exactly when masked status is non-zero, so it stays low while the mask is zero.
- R4: Writing the clear register (0x028) removes from raw status every bit written as 1. When an event pulse and a clear of the same bit fall in one cycle, the bit stays set.
- R5: A write to a read-only register (0x020, 0x024, 0x02C, 0x030) changes nothing and flags an error. A read of the clear register returns zero and flags an error.
- R6: An access to an undecoded offset, a misaligned offset (low two bits non-zero) or size code 3 returns zero on read. It raises the bus error output for exactly one cycle.
- R7: Palette words occupy offsets 0x200 to 0x3FC and cursor image words occupy 0x800 to 0xBFC. Each is indexed by (offset − window base) >> 2, and offsets 0x1FC and 0x400 lie outside.
- R8: Byte and halfword writes store their low 8 or 16 data bits zero-extended into the full word. A byte or halfword read returns only the low 8 or 16 bits of the word.
- R9: A write to control that takes the power bit from 0 to 1 pulses the fetch start output for one cycle and latches the watermark bit. Other control writes leave the latched watermark unchanged.
- R10: After reset every register, palette word and cursor word is zero, the interrupt is low, width reads 16 and height reads 1.
- R11: Read data with its valid flag, and any error flag, appear in the cycle after the access, and only for that cycle.
- R12: Both current-address offsets return the fetch engine's current address input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 12 | Byte offset |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, low lanes used for narrow writes |
| bus_rdata | output | 32 | Read data, one cycle after access |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Illegal or undecoded access, one cycle after access |
| cur_addr | input | 32 | Current fetch address from the fetch engine |
| ev_underflow | input | 1 | Underflow event pulse |
| ev_base_upd | input | 1 | Base address taken-up pulse |
| ev_master_err | input | 1 | Bus-master error pulse |
| irq | output | 1 | Level interrupt |
| fetch_start | output | 1 | One-cycle start request to the fetch engine |
| wm_sel | output | 1 | Latched watermark choice |
| lcd_en | output | 1 | Control enable bit |
| lcd_pwr | output | 1 | Control power bit |
| up_base | output | 32 | Upper frame base |
| lo_base | output | 32 | Lower frame base |
| act_width | output | 11 | Active width in pixels |
| act_height | output | 11 | Active height in lines |

## Verification
Each access is driven for one cycle and registered at the next rising edge. Read data, the valid flag and the error flag are therefore due one cycle after that edge. A queue entry records them for exactly that cycle, and the monitor compares one nanosecond after the edge. Width, height, masked status, the interrupt, the fetch start pulse and the latched watermark follow registers written at the same edge, so the bench samples them at the falling edge straight after it. It then samples again one cycle later to confirm that the start pulse, the read valid flag and the error flag have dropped.

// File: rtl/dctl_pkg.sv
package dctl_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int ST_W     = 4;
  localparam int NUM_REGS = 13;

  // status bit positions
  localparam int ST_UFL  = 0;
  localparam int ST_BASE = 1;
  localparam int ST_VCMP = 2;
  localparam int ST_MERR = 3;

  // control bit positions
  localparam int CTL_EN  = 0;
  localparam int CTL_PWR = 11;
  localparam int CTL_WM  = 16;

  // timing field layout
  localparam int PPL_LSB = 2;
  localparam int PPL_W   = 6;
  localparam int LPP_W   = 10;
  localparam int DIM_W   = LPP_W + 1;

  typedef enum logic [3:0] {
    RID_TIM0  = 4'd0,
    RID_TIM1  = 4'd1,
    RID_TIM2  = 4'd2,
    RID_TIM3  = 4'd3,
    RID_UPB   = 4'd4,
    RID_LOB   = 4'd5,
    RID_CTRL  = 4'd6,
    RID_MASK  = 4'd7,
    RID_RAW   = 4'd8,
    RID_MSKD  = 4'd9,
    RID_CLR   = 4'd10,
    RID_UPCUR = 4'd11,
    RID_LOCUR = 4'd12
  } rid_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_REG  = 2'd1,
    SRC_PAL  = 2'd2,
    SRC_CUR  = 2'd3
  } rsrc_e;
endpackage

// File: rtl/dctl_decode.sv
module dctl_decode
  import dctl_pkg::*;
#(
  parameter int PAL_WORDS = 128,
  parameter int CUR_WORDS = 256,
  localparam int PAL_IW = $clog2(PAL_WORDS),
  localparam int CUR_IW = $clog2(CUR_WORDS)
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              reg_hit,
  output rid_e              rid,
  output logic              pal_hit,
  output logic              cur_hit,
  output logic [PAL_IW-1:0] pal_idx,
  output logic [CUR_IW-1:0] cur_idx,
  output logic              bad
);
  localparam logic [ADDR_W-1:0] PAL_LO = ADDR_W'(32'h400 - PAL_WORDS * 4);
  localparam logic [ADDR_W-1:0] PAL_HI = ADDR_W'(32'h3FC);
  localparam logic [ADDR_W-1:0] CUR_LO = ADDR_W'(32'hC00 - CUR_WORDS * 4);
  localparam logic [ADDR_W-1:0] CUR_HI = ADDR_W'(32'hBFC);

  logic              fmt_ok;
  logic              known;
  logic              ro;
  logic              perm_ok;
  logic [ADDR_W-1:0] poff;
  logic [ADDR_W-1:0] coff;

  always_comb begin
    fmt_ok  = (size != 2'b11) && (addr[1:0] == 2'b00);
    known   = (addr[ADDR_W-1:2] < (ADDR_W-2)'(NUM_REGS));
    rid     = rid_e'(addr[5:2]);
    ro      = (rid == RID_RAW) || (rid == RID_MSKD) ||
              (rid == RID_UPCUR) || (rid == RID_LOCUR);
    perm_ok = wr ? !ro : (rid != RID_CLR);
    poff    = addr - PAL_LO;
    coff    = addr - CUR_LO;
    pal_idx = poff[PAL_IW+1:2];
    cur_idx = coff[CUR_IW+1:2];
    reg_hit = sel && fmt_ok && known && perm_ok;
    pal_hit = sel && fmt_ok && (addr >= PAL_LO) && (addr <= PAL_HI);
    cur_hit = sel && fmt_ok && (addr >= CUR_LO) && (addr <= CUR_HI);
    bad     = sel && !(reg_hit || pal_hit || cur_hit);
  end
endmodule

// File: rtl/dctl_wordmem.sv
module dctl_wordmem #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_q <= '0;
    end else begin
      if (we) mem[idx] <= wdata;
      if (re) rd_q <= mem[idx];
    end
  end

  assign rdata = rd_q;
endmodule

// File: rtl/dctl_status.sv
module dctl_status
  import dctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic [ST_W-1:0] mask_wdata,
  input  logic            clr_we,
  input  logic [ST_W-1:0] clr_wdata,
  input  logic [ST_W-1:0] ev_set,
  output logic [ST_W-1:0] mask_q,
  output logic [ST_W-1:0] raw_q,
  output logic [ST_W-1:0] masked,
  output logic            irq
);
  localparam logic [ST_W-1:0] IRQ_SRC =
    ST_W'((1 << ST_UFL) | (1 << ST_BASE) | (1 << ST_VCMP) | (1 << ST_MERR));

  logic [ST_W-1:0] mask_d;
  logic [ST_W-1:0] raw_d;

  always_comb begin
    mask_d = mask_we ? mask_wdata : mask_q;
    raw_d  = (clr_we ? (raw_q & ~clr_wdata) : raw_q) | ev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      mask_q <= mask_d;
      raw_q  <= raw_d;
    end
  end

  assign masked = mask_q & raw_q;
  assign irq    = |(masked & IRQ_SRC);

  // R4: an event pulse always lands in raw status, even against a clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((raw_q & $past(ev_set)) == $past(ev_set)));

  // R4: cleared bits without a competing event are gone next cycle
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((clr_wdata & ~ev_set) != '0)) |=>
      ((raw_q & $past(clr_wdata & ~ev_set)) == '0));

  // R3: no interrupt while the mask is empty
  a_r3_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

// File: rtl/dctl_regfile.sv
module dctl_regfile
  import dctl_pkg::*;
#(
  parameter int PAL_WORDS = 128,
  parameter int CUR_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  input  logic [DATA_W-1:0] cur_addr,
  input  logic              ev_underflow,
  input  logic              ev_base_upd,
  input  logic              ev_master_err,
  output logic              irq,
  output logic              fetch_start,
  output logic              wm_sel,
  output logic              lcd_en,
  output logic              lcd_pwr,
  output logic [DATA_W-1:0] up_base,
  output logic [DATA_W-1:0] lo_base,
  output logic [DIM_W-1:0]  act_width,
  output logic [DIM_W-1:0]  act_height
);
  localparam int PAL_IW = $clog2(PAL_WORDS);
  localparam int CUR_IW = $clog2(CUR_WORDS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  // decode
  logic              reg_hit, pal_hit, cur_hit, bad;
  rid_e              rid;
  logic [PAL_IW-1:0] pal_idx;
  logic [CUR_IW-1:0] cur_idx;

  dctl_decode #(.PAL_WORDS(PAL_WORDS), .CUR_WORDS(CUR_WORDS)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .size(bus_size),
    .reg_hit(reg_hit), .rid(rid), .pal_hit(pal_hit), .cur_hit(cur_hit),
    .pal_idx(pal_idx), .cur_idx(cur_idx), .bad(bad)
  );

  // write data, zero-extended by access size
  logic [DATA_W-1:0] wext;
  always_comb begin
    case (bus_size)
      2'd0:    wext = {{(DATA_W-8){1'b0}},  bus_wdata[7:0]};
      2'd1:    wext = {{(DATA_W-16){1'b0}}, bus_wdata[15:0]};
      default: wext = bus_wdata;
    endcase
  end

  logic wr_reg, rd_reg;
  assign wr_reg = reg_hit && bus_wr;
  assign rd_reg = reg_hit && !bus_wr;

  // status and interrupt
  logic [ST_W-1:0] mask_q, raw_q, masked, ev_set;
  assign ev_set = ST_W'((ev_underflow  << ST_UFL) |
                        (ev_base_upd   << ST_BASE) |
                        (ev_master_err << ST_MERR));

  dctl_status u_st (
    .clk(clk), .rst_n(rst_q),
    .mask_we(wr_reg && (rid == RID_MASK)), .mask_wdata(wext[ST_W-1:0]),
    .clr_we(wr_reg && (rid == RID_CLR)),   .clr_wdata(wext[ST_W-1:0]),
    .ev_set(ev_set), .mask_q(mask_q), .raw_q(raw_q), .masked(masked), .irq(irq)
  );

  // window memories
  logic [DATA_W-1:0] pal_rd, cur_rd;

  dctl_wordmem #(.DEPTH(PAL_WORDS), .DW(DATA_W)) u_pal (
    .clk(clk), .rst_n(rst_q),
    .we(pal_hit && bus_wr), .re(pal_hit && !bus_wr),
    .idx(pal_idx), .wdata(wext), .rdata(pal_rd)
  );

  dctl_wordmem #(.DEPTH(CUR_WORDS), .DW(DATA_W)) u_cur (
    .clk(clk), .rst_n(rst_q),
    .we(cur_hit && bus_wr), .re(cur_hit && !bus_wr),
    .idx(cur_idx), .wdata(wext), .rdata(cur_rd)
  );

  // configuration registers
  logic [DATA_W-1:0] tim_q [4];
  logic [DATA_W-1:0] tim_d [4];
  logic [DATA_W-1:0] upb_q, upb_d, lob_q, lob_d, ctrl_q, ctrl_d;
  logic              wm_q, wm_d, start_q, start_d, pwr_rise;

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_tim
      assign tim_d[g] = (wr_reg && (rid == rid_e'(g))) ? wext : tim_q[g];
      always_ff @(posedge clk or negedge rst_q) begin
        if (!rst_q) tim_q[g] <= '0;
        else        tim_q[g] <= tim_d[g];
      end
    end
  endgenerate

  always_comb begin
    upb_d    = (wr_reg && (rid == RID_UPB))  ? wext : upb_q;
    lob_d    = (wr_reg && (rid == RID_LOB))  ? wext : lob_q;
    ctrl_d   = (wr_reg && (rid == RID_CTRL)) ? wext : ctrl_q;
    pwr_rise = wr_reg && (rid == RID_CTRL) && wext[CTL_PWR] && !ctrl_q[CTL_PWR];
    start_d  = pwr_rise;
    wm_d     = pwr_rise ? wext[CTL_WM] : wm_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      upb_q   <= '0;
      lob_q   <= '0;
      ctrl_q  <= '0;
      wm_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      upb_q   <= upb_d;
      lob_q   <= lob_d;
      ctrl_q  <= ctrl_d;
      wm_q    <= wm_d;
      start_q <= start_d;
    end
  end

  // geometry follows the timing words as written
  logic [PPL_W-1:0] ppl;
  logic [LPP_W-1:0] lpp;
  assign ppl        = tim_q[0][PPL_LSB +: PPL_W];
  assign lpp        = tim_q[1][LPP_W-1:0];
  assign act_width  = DIM_W'((DIM_W'(ppl) + DIM_W'(1)) << 4);
  assign act_height = DIM_W'(lpp) + DIM_W'(1);

  // read path
  logic [DATA_W-1:0] rreg_d, rreg_q;
  rsrc_e             rsrc_d, rsrc_q;
  logic [1:0]        rsize_q;
  logic              rvalid_q, err_q, rd_any;
  logic [DATA_W-1:0] rsel, rmask;

  always_comb begin
    case (rid)
      RID_TIM0, RID_TIM1, RID_TIM2, RID_TIM3: rreg_d = tim_q[rid[1:0]];
      RID_UPB:   rreg_d = upb_q;
      RID_LOB:   rreg_d = lob_q;
      RID_CTRL:  rreg_d = ctrl_q;
      RID_MASK:  rreg_d = DATA_W'(mask_q);
      RID_RAW:   rreg_d = DATA_W'(raw_q);
      RID_MSKD:  rreg_d = DATA_W'(masked);
      RID_UPCUR: rreg_d = cur_addr;
      RID_LOCUR: rreg_d = cur_addr;
      default:   rreg_d = '0;
    endcase
    if (rd_reg)                  rsrc_d = SRC_REG;
    else if (pal_hit && !bus_wr) rsrc_d = SRC_PAL;
    else if (cur_hit && !bus_wr) rsrc_d = SRC_CUR;
    else                         rsrc_d = SRC_ZERO;
    rd_any = bus_sel && !bus_wr;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rreg_q   <= '0;
      rsrc_q   <= SRC_ZERO;
      rsize_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_any;
      err_q    <= bad;
      if (rd_any) begin
        rreg_q  <= rreg_d;
        rsrc_q  <= rsrc_d;
        rsize_q <= bus_size;
      end
    end
  end

  always_comb begin
    case (rsrc_q)
      SRC_REG: rsel = rreg_q;
      SRC_PAL: rsel = pal_rd;
      SRC_CUR: rsel = cur_rd;
      default: rsel = '0;
    endcase
    case (rsize_q)
      2'd0:    rmask = DATA_W'(32'h0000_00FF);
      2'd1:    rmask = DATA_W'(32'h0000_FFFF);
      default: rmask = '1;
    endcase
  end

  assign bus_rdata   = rvalid_q ? (rsel & rmask) : '0;
  assign bus_rvalid  = rvalid_q;
  assign bus_err     = err_q;
  assign fetch_start = start_q;
  assign wm_sel      = wm_q;
  assign lcd_en      = ctrl_q[CTL_EN];
  assign lcd_pwr     = ctrl_q[CTL_PWR];
  assign up_base     = upb_q;
  assign lo_base     = lob_q;

  // R11: every read is answered in the following cycle
  a_r11_read_answered: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  // R6: an errored response carries no data
  a_r6_err_zero_data: assert property (@(posedge clk) disable iff (!rst_q)
    bus_err |-> (bus_rdata == '0));

  // R9: start request is a single-cycle pulse issued with power on
  a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_q)
    fetch_start |=> !fetch_start);
  a_r9_start_powered: assert property (@(posedge clk) disable iff (!rst_q)
    fetch_start |-> lcd_pwr);

  // R5: a write aimed at raw status leaves it alone
  a_r5_raw_write_ignored: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_sel && bus_wr && (bus_addr == ADDR_W'(32'h020)) && (ev_set == '0))
      |=> $stable(raw_q));
endmodule

// File: tb/sim_dctl_regfile.sv
module sim_dctl_regfile;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata, bus_rdata, cur_addr, up_base, lo_base;
  logic        bus_rvalid, bus_err;
  logic        ev_underflow, ev_base_upd, ev_master_err;
  logic        irq, fetch_start, wm_sel, lcd_en, lcd_pwr;
  logic [10:0] act_width, act_height;

  dctl_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
    .cur_addr(cur_addr), .ev_underflow(ev_underflow), .ev_base_upd(ev_base_upd),
    .ev_master_err(ev_master_err), .irq(irq), .fetch_start(fetch_start),
    .wm_sel(wm_sel), .lcd_en(lcd_en), .lcd_pwr(lcd_pwr), .up_base(up_base),
    .lo_base(lo_base), .act_width(act_width), .act_height(act_height)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    bit          rv;
    logic [31:0] d;
    bit          e;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: one response is due right after the edge that took the access
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        n_cmp++;
        if (bus_rvalid !== it.rv || bus_err !== it.e ||
            (it.rv && bus_rdata !== it.d)) begin
          n_bad++;
          $display("FAIL %s: got rv=%0b err=%0b data=%h expected rv=%0b err=%0b data=%h",
                   it.tag, bus_rvalid, bus_err, bus_rdata, it.rv, it.e, it.d);
        end
      end
    end
  end

  // driver: one access cycle, optional event pulses in the same cycle
  task automatic acc(input bit dosel, input bit wr, input logic [11:0] a,
                     input logic [1:0] sz, input logic [31:0] wd, input logic [2:0] ev,
                     input logic [31:0] exp_d, input bit exp_e, input string tag);
    @(negedge clk);
    bus_sel = dosel; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    {ev_master_err, ev_base_upd, ev_underflow} = ev;
    if (dosel) begin
      exp_t it;
      it.rv = !wr; it.d = exp_d; it.e = exp_e; it.tag = tag;
      q.push_back(it);
    end
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; {ev_master_err, ev_base_upd, ev_underflow} = 3'b000;
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d, input string tag);
    acc(1, 1, a, 2'd2, d, 3'b000, 32'h0, 0, tag);
  endtask

  task automatic rd32(input logic [11:0] a, input logic [31:0] e, input string tag);
    acc(1, 0, a, 2'd2, 32'h0, 3'b000, e, 0, tag);
  endtask

  task automatic pulse(input logic [2:0] ev);
    acc(0, 0, 12'h0, 2'd2, 32'h0, ev, 32'h0, 0, "");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_size = 2'd2; bus_wdata = '0;
    cur_addr = '0; ev_underflow = 0; ev_base_upd = 0; ev_master_err = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk(act_width, 32'd16, "R10 width after reset");
    chk(act_height, 32'd1, "R10 height after reset");
    chk(irq, 0, "R10 irq after reset");
    rd32(12'h018, 32'h0, "R10 control after reset");
    rd32(12'h3FC, 32'h0, "R10 palette after reset");

    // R1 / R2 geometry
    wr32(12'h000, 32'h0000_009C, "R1 write timing0");
    chk(act_width, 32'd640, "R1 width 640");
    wr32(12'h000, 32'h0000_00FC, "R1 write timing0 max");
    chk(act_width, 32'd1024, "R1 width 1024");
    rd32(12'h000, 32'h0000_00FC, "R1 timing0 readback");
    wr32(12'h004, 32'd479, "R2 write timing1");
    chk(act_height, 32'd480, "R2 height 480");

    // R8 access sizes
    acc(1, 1, 12'h010, 2'd0, 32'h1234_5678, 3'b000, 32'h0, 0, "R8 byte write");
    rd32(12'h010, 32'h0000_0078, "R8 byte write zero-extended");
    chk(up_base, 32'h78, "R8 up_base");
    acc(1, 1, 12'h014, 2'd1, 32'hFFFF_9ABC, 3'b000, 32'h0, 0, "R8 half write");
    chk(lo_base, 32'h9ABC, "R8 lo_base");
    wr32(12'h008, 32'hAABB_CCDD, "R8 word write");
    acc(1, 0, 12'h008, 2'd1, 32'h0, 3'b000, 32'h0000_CCDD, 0, "R8 half read");
    acc(1, 0, 12'h008, 2'd0, 32'h0, 3'b000, 32'h0000_00DD, 0, "R8 byte read");
    rd32(12'h008, 32'hAABB_CCDD, "R8 word read");

    // R11 valid lasts one cycle
    rd32(12'h004, 32'd479, "R11 read timing1");
    chk(bus_rvalid, 1, "R11 valid in response cycle");
    @(negedge clk);
    chk(bus_rvalid, 0, "R11 valid dropped");

    // R7 windows
    wr32(12'h200, 32'hCAFE_0001, "R7 palette first");
    wr32(12'h3FC, 32'h1234_5678, "R7 palette last");
    wr32(12'h800, 32'h0BAD_F00D, "R7 cursor first");
    wr32(12'hBFC, 32'h55AA_55AA, "R7 cursor last");
    rd32(12'h200, 32'hCAFE_0001, "R7 palette first readback");
    rd32(12'h3FC, 32'h1234_5678, "R7 palette last readback");
    rd32(12'h800, 32'h0BAD_F00D, "R7 cursor first readback");
    rd32(12'hBFC, 32'h55AA_55AA, "R7 cursor last readback");
    rd32(12'h204, 32'h0, "R7 palette neighbour untouched");
    acc(1, 0, 12'h400, 2'd2, 32'h0, 3'b000, 32'h0, 1, "R7 offset 0x400 outside");
    acc(1, 0, 12'h1FC, 2'd2, 32'h0, 3'b000, 32'h0, 1, "R7 offset 0x1FC outside");

    // R6 undecoded, misaligned, bad size
    acc(1, 0, 12'h034, 2'd2, 32'h0, 3'b000, 32'h0, 1, "R6 undecoded read");
    chk(bus_err, 1, "R6 err raised");
    @(negedge clk);
    chk(bus_err, 0, "R6 err one cycle");
    acc(1, 0, 12'h002, 2'd1, 32'h0, 3'b000, 32'h0, 1, "R6 misaligned read");
    acc(1, 0, 12'h000, 2'd3, 32'h0, 3'b000, 32'h0, 1, "R6 size 3 read");
    acc(1, 1, 12'h010, 2'd3, 32'hFFFF_FFFF, 3'b000, 32'h0, 1, "R6 size 3 write");
    rd32(12'h010, 32'h0000_0078, "R6 bad write left upper base");

    // R5 permissions
    acc(1, 1, 12'h020, 2'd2, 32'hF, 3'b000, 32'h0, 1, "R5 write raw");
    rd32(12'h020, 32'h0, "R5 raw unchanged");
    acc(1, 0, 12'h028, 2'd2, 32'h0, 3'b000, 32'h0, 1, "R5 read clear");
    acc(1, 1, 12'h02C, 2'd2, 32'h1, 3'b000, 32'h0, 1, "R5 write current address");

    // R12 current address
    cur_addr = 32'h0000_4440;
    rd32(12'h02C, 32'h0000_4440, "R12 upper current");
    rd32(12'h030, 32'h0000_4440, "R12 lower current");

    // R3 / R4 status and interrupt
    pulse(3'b001);
    rd32(12'h020, 32'h1, "R4 underflow set");
    chk(irq, 0, "R3 masked off");
    rd32(12'h024, 32'h0, "R3 masked status zero");
    wr32(12'h01C, 32'h1, "R3 mask underflow");
    chk(irq, 1, "R3 irq on mask");
    rd32(12'h024, 32'h1, "R3 masked status one");
    pulse(3'b010);
    rd32(12'h024, 32'h1, "R3 base bit masked off");
    wr32(12'h028, 32'h1, "R4 clear underflow");
    chk(irq, 0, "R3 irq drops");
    rd32(12'h020, 32'h2, "R4 raw after clear");
    wr32(12'h01C, 32'hF, "R3 mask all");
    chk(irq, 1, "R3 irq base bit");
    pulse(3'b100);
    rd32(12'h020, 32'hA, "R4 master error set");
    acc(1, 1, 12'h028, 2'd2, 32'hA, 3'b100, 32'h0, 0, "R4 clear with event");
    rd32(12'h020, 32'h8, "R4 set wins");
    chk(irq, 1, "R3 irq held");
    wr32(12'h028, 32'h8, "R4 clear last");
    chk(irq, 0, "R3 irq low");

    // R9 power rise
    wr32(12'h018, 32'h0001_0801, "R9 power on wm1");
    chk(fetch_start, 1, "R9 start pulse");
    chk(wm_sel, 1, "R9 wm latched");
    chk(lcd_pwr, 1, "R9 power bit");
    chk(lcd_en, 1, "R9 enable bit");
    @(negedge clk);
    chk(fetch_start, 0, "R9 pulse one cycle");
    wr32(12'h018, 32'h0000_0801, "R9 power held");
    chk(fetch_start, 0, "R9 no pulse when held");
    chk(wm_sel, 1, "R9 wm kept");
    wr32(12'h018, 32'h0, "R9 power off");
    wr32(12'h018, 32'h0000_0800, "R9 power on wm0");
    chk(fetch_start, 1, "R9 second start");
    chk(wm_sel, 0, "R9 wm relatched");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule